// File: doc/BRIEF.md
# Load-Use Hazard Interlock

This block protects an in-order pipeline from reading a register before a load has delivered its value. It looks at the instruction in the register-read stage and compares each source register it actually reads with the destination of any load still in the ALU stage or the MEM stage. Load data can be forwarded only from the write-back stage. On a match the block holds the program counter and the fetch-to-decode register. It also places a bubble into the ALU-stage instruction register, so the dependent instruction stays where it is.

The block keeps its own ALU-stage and MEM-stage control registers: destination, load flag, register write enable and memory write enable. It drives these registers out for the rest of the pipeline. A load followed directly by a consumer costs two bubbles. With one instruction between them it costs one bubble, and with two or more between them it costs none. An injected bubble has every write enable cleared, so it cannot change architectural state.

Top module: `load_use_interlock`

## Requirements
- R1: While reset is high, both stage control registers clear to zero on each clock edge (destination 0, all flags 0).
- R2: A valid decode instruction stalls when a source it reads matches the destination of a load in the ALU stage. A consumer issued directly after a load therefore sees exactly 2 stall cycles.
- R3: A valid decode instruction stalls when a source it reads matches the destination of a load in the MEM stage. A consumer two instructions after a load sees 1 stall cycle; one three instructions after sees none.
- R4: A source register number of 0 never causes a stall.
- R5: A source whose use flag is 0 never causes a stall. A decode slot with `id_valid` low never causes a stall and enters the ALU stage as a bubble.
- R6: A matching destination of an instruction that is not a load never causes a stall.
- R7: `pc_hold`, `fd_hold` and `bubble` are combinational, always equal, and high in exactly the cycles in which a stall is detected.
- R8: On the clock edge that ends a stall cycle, the ALU-stage register loads a bubble: destination 0, load 0, register write 0, memory write 0.
- R9: On the clock edge that ends a cycle without a stall, the ALU-stage register takes the decode fields. On every edge the MEM-stage register takes the previous ALU-stage fields.
- R10: Every source is checked. Source k occupies bits [5k+4:5k] of `id_rs` and is qualified by bit k of `id_rs_used`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| id_valid | input | 1 | Decode stage holds a real instruction |
| id_rs | input | NSRC*5 | Packed source register numbers of the decode instruction |
| id_rs_used | input | NSRC | Per-source read flag |
| id_rd | input | 5 | Destination of the decode instruction |
| id_load | input | 1 | Decode instruction is a load |
| id_reg_we | input | 1 | Decode instruction writes the register file |
| id_mem_we | input | 1 | Decode instruction writes memory |
| pc_hold | output | 1 | Hold the program counter |
| fd_hold | output | 1 | Hold the fetch-to-decode register |
| bubble | output | 1 | A bubble is injected into the ALU stage at the next edge |
| ex_rd | output | 5 | ALU-stage destination |
| ex_load | output | 1 | ALU-stage load flag |
| ex_reg_we | output | 1 | ALU-stage register write enable |
| ex_mem_we | output | 1 | ALU-stage memory write enable |
| mem_rd | output | 5 | MEM-stage destination |
| mem_load | output | 1 | MEM-stage load flag |
| mem_reg_we | output | 1 | MEM-stage register write enable |
| mem_mem_we | output | 1 | MEM-stage memory write enable |

## Verification
The three hold signals are combinational, so the bench samples them 1 ns after the falling edge, with the decode fields already applied. It counts stall cycles per issued instruction and compares the count with the count the requirements give for that load distance. The ALU-stage register changes one edge after a decode slot is used, and the MEM-stage register one edge later. The scoreboard therefore pops one expected ALU-stage item 1 ns after every rising edge, either a bubble or the instruction. In that same sample it compares the MEM-stage outputs with the ALU-stage values recorded one edge earlier.

// File: rtl/lui_pkg.sv
package lui_pkg;
  localparam int unsigned RF_AW = 5;

  typedef struct packed {
    logic [RF_AW-1:0] rd;
    logic             load;
    logic             reg_we;
    logic             mem_we;
  } ctl_t;

  localparam ctl_t CTL_NOP = '{rd: '0, load: 1'b0, reg_we: 1'b0, mem_we: 1'b0};
endpackage

// File: rtl/lui_src_match.sv
module lui_src_match
  import lui_pkg::*;
#(
  parameter int unsigned NSRC = 2
) (
  input  logic [NSRC*RF_AW-1:0] rs,
  input  logic [NSRC-1:0]       rs_used,
  input  ctl_t                  stg,
  output logic                  hit
);
  logic [NSRC-1:0] hit_v;

  genvar i;
  generate
    for (i = 0; i < NSRC; i++) begin : g_src
      logic [RF_AW-1:0] r;
      assign r        = rs[i*RF_AW +: RF_AW];
      assign hit_v[i] = rs_used[i] && (r != '0) && stg.load && (stg.rd == r);
    end
  endgenerate

  assign hit = |hit_v;
endmodule

// File: rtl/lui_ctl_reg.sv
module lui_ctl_reg
  import lui_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  ctl_t d,
  output ctl_t q
);
  always_ff @(posedge clk) begin
    if (rst || clr) q <= CTL_NOP;
    else            q <= d;
  end
endmodule

// File: rtl/load_use_interlock.sv
module load_use_interlock
  import lui_pkg::*;
#(
  parameter int unsigned NSRC = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  id_valid,
  input  logic [NSRC*RF_AW-1:0] id_rs,
  input  logic [NSRC-1:0]       id_rs_used,
  input  logic [RF_AW-1:0]      id_rd,
  input  logic                  id_load,
  input  logic                  id_reg_we,
  input  logic                  id_mem_we,
  output logic                  pc_hold,
  output logic                  fd_hold,
  output logic                  bubble,
  output logic [RF_AW-1:0]      ex_rd,
  output logic                  ex_load,
  output logic                  ex_reg_we,
  output logic                  ex_mem_we,
  output logic [RF_AW-1:0]      mem_rd,
  output logic                  mem_load,
  output logic                  mem_reg_we,
  output logic                  mem_mem_we
);
  localparam int unsigned NSTG = 2;

  ctl_t            id_ctl;
  ctl_t            stg_q [NSTG];
  ctl_t            stg_d [NSTG];
  logic [NSTG-1:0] stg_clr;
  logic [NSTG-1:0] stg_hit;
  logic            stall;

  assign id_ctl = id_valid ? '{rd: id_rd, load: id_load, reg_we: id_reg_we, mem_we: id_mem_we}
                           : CTL_NOP;

  // stage 0 = ALU stage, stage 1 = MEM stage
  genvar s;
  generate
    for (s = 0; s < NSTG; s++) begin : g_stg
      lui_src_match #(.NSRC(NSRC)) u_match (
        .rs      (id_rs),
        .rs_used (id_rs_used),
        .stg     (stg_q[s]),
        .hit     (stg_hit[s])
      );
      if (s == 0) begin : g_first
        assign stg_d[s]   = id_ctl;
        assign stg_clr[s] = stall;
      end else begin : g_next
        assign stg_d[s]   = stg_q[s-1];
        assign stg_clr[s] = 1'b0;
      end
      lui_ctl_reg u_reg (
        .clk (clk),
        .rst (rst),
        .clr (stg_clr[s]),
        .d   (stg_d[s]),
        .q   (stg_q[s])
      );
    end
  endgenerate

  assign stall   = id_valid && (|stg_hit);
  assign pc_hold = stall;
  assign fd_hold = stall;
  assign bubble  = stall;

  assign ex_rd      = stg_q[0].rd;
  assign ex_load    = stg_q[0].load;
  assign ex_reg_we  = stg_q[0].reg_we;
  assign ex_mem_we  = stg_q[0].mem_we;
  assign mem_rd     = stg_q[1].rd;
  assign mem_load   = stg_q[1].load;
  assign mem_reg_we = stg_q[1].reg_we;
  assign mem_mem_we = stg_q[1].mem_we;
endmodule

// File: rtl/lui_interlock_chk.sv
module lui_interlock_chk
  import lui_pkg::*;
#(
  parameter int unsigned NSRC = 2
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  id_valid,
  input logic [NSRC*RF_AW-1:0] id_rs,
  input logic [NSRC-1:0]       id_rs_used,
  input logic [RF_AW-1:0]      id_rd,
  input logic                  id_load,
  input logic                  id_reg_we,
  input logic                  id_mem_we,
  input logic                  pc_hold,
  input logic                  bubble,
  input logic [RF_AW-1:0]      ex_rd,
  input logic                  ex_load,
  input logic                  ex_reg_we,
  input logic                  ex_mem_we,
  input logic [RF_AW-1:0]      mem_rd,
  input logic                  mem_load,
  input logic                  mem_reg_we,
  input logic                  mem_mem_we
);
  logic any_live_src;
  always_comb begin
    any_live_src = 1'b0;
    for (int i = 0; i < NSRC; i++)
      if (id_rs_used[i] && id_rs[i*RF_AW +: RF_AW] != '0) any_live_src = 1'b1;
  end

  // R1
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (ex_rd == '0 && !ex_load && !ex_reg_we && !ex_mem_we &&
             mem_rd == '0 && !mem_load && !mem_reg_we && !mem_mem_we));

  // R8
  bubble_is_nop_chk: assert property (@(posedge clk) disable iff (rst)
    bubble |=> (ex_rd == '0 && !ex_load && !ex_reg_we && !ex_mem_we));

  // R9
  ex_takes_decode_chk: assert property (@(posedge clk) disable iff (rst)
    (!bubble && id_valid) |=> (ex_rd == $past(id_rd) && ex_load == $past(id_load) &&
                               ex_reg_we == $past(id_reg_we) && ex_mem_we == $past(id_mem_we)));

  // R9
  mem_follows_ex_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (mem_rd == $past(ex_rd) && mem_load == $past(ex_load) &&
              mem_reg_we == $past(ex_reg_we) && mem_mem_we == $past(ex_mem_we)));

  // R4
  no_live_src_no_stall_chk: assert property (@(posedge clk) disable iff (rst)
    !any_live_src |-> !pc_hold);

  // R5
  invalid_no_stall_chk: assert property (@(posedge clk) disable iff (rst)
    !id_valid |-> !pc_hold);

  // R6
  no_load_no_stall_chk: assert property (@(posedge clk) disable iff (rst)
    (!ex_load && !mem_load) |-> !pc_hold);
endmodule

bind load_use_interlock lui_interlock_chk #(.NSRC(NSRC)) u_chk (
  .clk(clk), .rst(rst), .id_valid(id_valid), .id_rs(id_rs), .id_rs_used(id_rs_used),
  .id_rd(id_rd), .id_load(id_load), .id_reg_we(id_reg_we), .id_mem_we(id_mem_we),
  .pc_hold(pc_hold), .bubble(bubble),
  .ex_rd(ex_rd), .ex_load(ex_load), .ex_reg_we(ex_reg_we), .ex_mem_we(ex_mem_we),
  .mem_rd(mem_rd), .mem_load(mem_load), .mem_reg_we(mem_reg_we), .mem_mem_we(mem_mem_we)
);

// File: tb/sim_load_use_interlock.sv
`timescale 1ns/100ps
module sim_load_use_interlock;
  import lui_pkg::*;

  localparam int unsigned NSRC = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic id_valid = 1'b0;
  logic [NSRC*RF_AW-1:0] id_rs = '0;
  logic [NSRC-1:0] id_rs_used = '0;
  logic [RF_AW-1:0] id_rd = '0;
  logic id_load = 1'b0, id_reg_we = 1'b0, id_mem_we = 1'b0;
  logic pc_hold, fd_hold, bubble;
  logic [RF_AW-1:0] ex_rd, mem_rd;
  logic ex_load, ex_reg_we, ex_mem_we, mem_load, mem_reg_we, mem_mem_we;

  always #2.5 clk = ~clk;

  load_use_interlock #(.NSRC(NSRC)) u0 (
    .clk(clk), .rst(rst), .id_valid(id_valid), .id_rs(id_rs), .id_rs_used(id_rs_used),
    .id_rd(id_rd), .id_load(id_load), .id_reg_we(id_reg_we), .id_mem_we(id_mem_we),
    .pc_hold(pc_hold), .fd_hold(fd_hold), .bubble(bubble),
    .ex_rd(ex_rd), .ex_load(ex_load), .ex_reg_we(ex_reg_we), .ex_mem_we(ex_mem_we),
    .mem_rd(mem_rd), .mem_load(mem_load), .mem_reg_we(mem_reg_we), .mem_mem_we(mem_mem_we)
  );

  typedef struct {
    ctl_t  c;
    string tag;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   errors = 0;
  bit   mon_en = 1'b0;
  bit   done   = 1'b0;
  ctl_t prev_ex;

  function automatic ctl_t ex_now();
    return '{rd: ex_rd, load: ex_load, reg_we: ex_reg_we, mem_we: ex_mem_we};
  endfunction

  function automatic ctl_t mem_now();
    return '{rd: mem_rd, load: mem_load, reg_we: mem_reg_we, mem_we: mem_mem_we};
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Scoreboard monitor: one expected ALU-stage item per rising edge while enabled
  always @(posedge clk) begin
    #1;
    if (mon_en && q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      check(ex_now() == e.c, {e.tag, " ALU stage"}, int'(ex_now()), int'(e.c));
      check(mem_now() == prev_ex, "R9 MEM stage follows ALU stage", int'(mem_now()), int'(prev_ex));
    end
    prev_ex = ex_now();
  end

  task automatic issue(input bit v, input logic [RF_AW-1:0] rd,
                       input logic [RF_AW-1:0] s0, input bit us0,
                       input logic [RF_AW-1:0] s1, input bit us1,
                       input bit ld, input bit rwe, input bit mwe,
                       input int exp_b, input string tag);
    int  cnt;
    bit  st;
    exp_t e;
    id_valid   = v;
    id_rd      = rd;
    id_rs      = {s1, s0};
    id_rs_used = {us1, us0};
    id_load    = ld;
    id_reg_we  = rwe;
    id_mem_we  = mwe;
    for (int k = 0; k < exp_b; k++) begin
      e.c = CTL_NOP; e.tag = "R8 bubble"; q.push_back(e);
    end
    e.c   = v ? ctl_t'{rd: rd, load: ld, reg_we: rwe, mem_we: mwe} : CTL_NOP;
    e.tag = v ? "R9 decode enters ALU stage" : "R5 invalid slot as bubble";
    q.push_back(e);
    cnt = 0;
    forever begin
      #1;
      st = pc_hold;
      check(fd_hold == st && bubble == st, "R7 hold signals agree",
            int'({pc_hold, fd_hold, bubble}), int'({3{st}}));
      if (st) cnt++;
      if (cnt > 4) break;
      @(negedge clk);
      if (!st) break;
    end
    check(cnt == exp_b, tag, cnt, exp_b);
  endtask

  task automatic nop_ins();
    issue(1'b1, 5'd0, 5'd0, 1'b0, 5'd0, 1'b0, 1'b0, 1'b0, 1'b0, 0, "R5 filler");
  endtask

  task automatic load(input logic [RF_AW-1:0] rd);
    issue(1'b1, rd, 5'd0, 1'b0, 5'd0, 1'b0, 1'b1, 1'b1, 1'b0, 0, "R3 load issue");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(ex_now() == CTL_NOP && mem_now() == CTL_NOP, "R1 reset state",
          int'({ex_now(), mem_now()}), 0);
    check(!pc_hold, "R1 no stall in reset", int'(pc_hold), 0);
    @(negedge clk);
    rst = 1'b0;
    mon_en = 1'b1;

    // distance 1 through source 0
    load(5'd5);
    issue(1'b1, 5'd7, 5'd5, 1'b1, 5'd0, 1'b0, 1'b0, 1'b1, 1'b0, 2, "R2 distance 1 bubbles");
    nop_ins(); nop_ins();
    // distance 2
    load(5'd6); nop_ins();
    issue(1'b1, 5'd7, 5'd6, 1'b1, 5'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1, "R3 distance 2 bubbles");
    nop_ins(); nop_ins();
    // distance 3
    load(5'd8); nop_ins(); nop_ins();
    issue(1'b1, 5'd7, 5'd8, 1'b1, 5'd0, 1'b0, 1'b0, 1'b1, 1'b0, 0, "R3 distance 3 bubbles");
    nop_ins(); nop_ins();
    // distance 1 through source 1
    load(5'd9);
    issue(1'b1, 5'd7, 5'd0, 1'b0, 5'd9, 1'b1, 1'b0, 1'b1, 1'b0, 2, "R10 source 1 bubbles");
    nop_ins(); nop_ins();
    // register 0
    load(5'd0);
    issue(1'b1, 5'd7, 5'd0, 1'b1, 5'd0, 1'b1, 1'b0, 1'b1, 1'b0, 0, "R4 register 0 bubbles");
    nop_ins(); nop_ins();
    // unused source
    load(5'd10);
    issue(1'b1, 5'd7, 5'd10, 1'b0, 5'd10, 1'b0, 1'b0, 1'b1, 1'b0, 0, "R5 unused source bubbles");
    nop_ins(); nop_ins();
    // invalid slot
    load(5'd11);
    issue(1'b0, 5'd7, 5'd11, 1'b1, 5'd11, 1'b1, 1'b1, 1'b1, 1'b1, 0, "R5 invalid slot bubbles");
    nop_ins(); nop_ins();
    // non-load producer
    issue(1'b1, 5'd12, 5'd0, 1'b0, 5'd0, 1'b0, 1'b0, 1'b1, 1'b0, 0, "R6 alu producer issue");
    issue(1'b1, 5'd7, 5'd12, 1'b1, 5'd12, 1'b1, 1'b0, 1'b1, 1'b0, 0, "R6 non-load bubbles");
    nop_ins(); nop_ins();
    // two loads, both sources dependent
    load(5'd1); load(5'd2);
    issue(1'b1, 5'd7, 5'd1, 1'b1, 5'd2, 1'b1, 1'b0, 1'b1, 1'b0, 2, "R2 two loads bubbles");
    nop_ins(); nop_ins();
    // dependent store: bubbles must carry no memory write
    load(5'd3);
    issue(1'b1, 5'd0, 5'd4, 1'b1, 5'd3, 1'b1, 1'b0, 1'b0, 1'b1, 2, "R8 store after load bubbles");
    nop_ins(); nop_ins();

    id_valid = 1'b0;
    @(negedge clk);
    check(q.size() == 0, "R9 scoreboard drained", q.size(), 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #50000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule